// File: doc/BRIEF.md
# Two-Player Tug-of-War Game Core

Two players fight over a lit marker on a row of nine positions. Each player has one push-button. Both button inputs arrive asynchronous to the clock. Each one goes through a two-stage flip-flop synchronizer, and then through a press detector that gives a single-cycle pulse for each press, however long the button is held. A press from the left player moves the marker one position toward the left end. A press from the right player moves it one position toward the right end. Presses from both players in the same cycle cancel out.

The playfield is a row of identical per-position state machines. Each cell looks only at its two neighbours and at the two press pulses to decide whether it is lit in the next cycle. A separate victory detector watches both ends of the row. When the marker is pushed off an end, it latches the winner, blanks the playfield, and shows the winning player's number on one active-low seven-segment digit. The game then ignores all presses until reset. The only interfaces are plain control pins, so no valid/ready handshake is used and there is no back-pressure: a press that arrives while the game is frozen is dropped.

Top module: `tow_game`

## Requirements
- R1: While `rst` is high at a rising edge, the next state is: only `field` bit 4 (the centre) is lit, and `seg_n` is 7'b1111111 (blank).
- R2: While no winner is shown, exactly one bit of `field` is high. Bit 8 is the left end and bit 0 is the right end.
- R3: A raw button that rises between edges shows its effect on `field` only after the third rising edge that follows. Two edges are spent in the synchronizer and one in the cell registers.
- R4: One press moves the marker by exactly one position, whether the button is held for 1 cycle or for 20 cycles.
- R5: A left press moves the lit bit from index i to i+1. A right press moves it from i to i-1.
- R6: When the left and right press pulses fall in the same cycle, `field` does not change.
- R7: A left-only press while bit 8 is lit declares the left player the winner. `field` becomes all zero and `seg_n` becomes 7'b1111001 (digit "1", bit order g..a, active-low).
- R8: A right-only press while bit 0 is lit declares the right player the winner. `field` becomes all zero and `seg_n` becomes 7'b0100100 (digit "2").
- R9: After a win, `field` stays all zero and `seg_n` holds its digit, whatever is pressed, until reset.
- R10: A reset applied after a win restores the R1 state, and play then resumes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| btn_left_raw | input | 1 | Left player's button, asynchronous, active high |
| btn_right_raw | input | 1 | Right player's button, asynchronous, active high |
| field | output | 9 | Playfield, one-hot; bit 8 is the left end |
| seg_n | output | 7 | Winner digit, active-low, bits g..a |

## Verification
The marker is driven by single presses of each hand, with hold lengths of 1, 5 and 20 cycles. This separates true edge detection from level sensing. Simultaneous presses from both hands check that the two pulses cancel rather than one side taking priority. The marker is walked all the way to each end and then pushed once more, which exercises both win paths. Further presses after the win, followed by a reset, show that the freeze holds and that reset fully restores play. One press is timed cycle by cycle to confirm the three-edge latency from raw input to playfield.

// File: rtl/tow_pkg.sv
package tow_pkg;
  typedef enum logic [1:0] {
    WIN_NONE  = 2'd0,
    WIN_LEFT  = 2'd1,
    WIN_RIGHT = 2'd2
  } winner_e;

  // active-low segment patterns, bit order g..a
  localparam logic [6:0] SEG_BLANK = 7'b1111111;
  localparam logic [6:0] SEG_ONE   = 7'b1111001;
  localparam logic [6:0] SEG_TWO   = 7'b0100100;

  localparam int SIDE_LEFT  = 1;
  localparam int SIDE_RIGHT = 0;
endpackage

// File: rtl/tow_sync.sv
module tow_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-2:0], din};
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/tow_press.sv
module tow_press (
  input  logic clk,
  input  logic rst,
  input  logic level,
  output logic pulse
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= level;
  end

  // high only in the first cycle of a held level
  assign pulse = level & ~prev_q;
endmodule

// File: rtl/tow_cell.sv
module tow_cell #(
  parameter bit IS_HOME = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic freeze,
  input  logic nbr_left,
  input  logic nbr_right,
  input  logic mv_left,
  input  logic mv_right,
  output logic lit
);
  logic lit_d;

  always_comb begin
    lit_d = (lit & ~(mv_left | mv_right))
          | (nbr_right & mv_left)
          | (nbr_left & mv_right);
  end

  always_ff @(posedge clk) begin
    if (rst)         lit <= IS_HOME;
    else if (freeze) lit <= 1'b0;
    else             lit <= lit_d;
  end
endmodule

// File: rtl/tow_victory.sv
module tow_victory
  import tow_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       end_left,
  input  logic       end_right,
  input  logic       mv_left,
  input  logic       mv_right,
  output logic       frozen,
  output logic [6:0] seg_n
);
  winner_e win_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q <= WIN_NONE;
    end else if (win_q == WIN_NONE) begin
      if (end_left && mv_left)        win_q <= WIN_LEFT;
      else if (end_right && mv_right) win_q <= WIN_RIGHT;
    end
  end

  assign frozen = (win_q != WIN_NONE);

  always_comb begin
    unique case (win_q)
      WIN_LEFT:  seg_n = SEG_ONE;
      WIN_RIGHT: seg_n = SEG_TWO;
      default:   seg_n = SEG_BLANK;
    endcase
  end
endmodule

// File: rtl/tow_game.sv
module tow_game #(
  parameter int N_POS       = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             btn_left_raw,
  input  logic             btn_right_raw,
  output logic [N_POS-1:0] field,
  output logic [6:0]       seg_n
);
  import tow_pkg::*;

  localparam int HOME = N_POS / 2;

  logic [1:0]       raw;
  logic [1:0]       synced;
  logic [1:0]       press;
  logic             press_l;
  logic             press_r;
  logic             frozen;
  logic             mv_l;
  logic             mv_r;
  logic [N_POS+1:0] ext;

  assign raw[SIDE_LEFT]  = btn_left_raw;
  assign raw[SIDE_RIGHT] = btn_right_raw;

  for (genvar s = 0; s < 2; s++) begin : g_side
    tow_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .din (raw[s]),
      .dout(synced[s])
    );
    tow_press u_press (
      .clk  (clk),
      .rst  (rst),
      .level(synced[s]),
      .pulse(press[s])
    );
  end

  assign press_l = press[SIDE_LEFT];
  assign press_r = press[SIDE_RIGHT];
  assign mv_l    = press_l & ~press_r & ~frozen;
  assign mv_r    = press_r & ~press_l & ~frozen;

  // padded row: cells beyond either end read as dark
  assign ext = {1'b0, field, 1'b0};

  for (genvar i = 0; i < N_POS; i++) begin : g_cell
    tow_cell #(.IS_HOME(i == HOME)) u_cell (
      .clk      (clk),
      .rst      (rst),
      .freeze   (frozen),
      .nbr_left (ext[i+2]),
      .nbr_right(ext[i]),
      .mv_left  (mv_l),
      .mv_right (mv_r),
      .lit      (field[i])
    );
  end

  tow_victory u_victory (
    .clk      (clk),
    .rst      (rst),
    .end_left (field[N_POS-1]),
    .end_right(field[0]),
    .mv_left  (mv_l),
    .mv_right (mv_r),
    .frozen   (frozen),
    .seg_n    (seg_n)
  );
endmodule

// File: rtl/tow_game_chk.sv
module tow_game_chk #(
  parameter int N_POS = 9
) (
  input logic             clk,
  input logic             rst,
  input logic             press_l,
  input logic             press_r,
  input logic [N_POS-1:0] field,
  input logic [6:0]       seg_n
);
  import tow_pkg::*;

  localparam logic [N_POS-1:0] HOME_MASK = 1 << (N_POS / 2);

  // R1: reset state
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (field == HOME_MASK && seg_n == SEG_BLANK));

  // R2: one lit position during play
  assert_one_hot_R2: assert property (@(posedge clk) disable iff (rst)
    (seg_n == SEG_BLANK) |-> ($countones(field) == 1));

  // R4: a press pulse never lasts two cycles
  assert_pulse_single_R4: assert property (@(posedge clk) disable iff (rst)
    (press_l || press_r) |=> !($past(press_l) && press_l) && !($past(press_r) && press_r));

  // R5: left step
  assert_step_left_R5: assert property (@(posedge clk) disable iff (rst)
    (press_l && !press_r && seg_n == SEG_BLANK && !field[N_POS-1])
      |=> (field == ($past(field) << 1)));

  // R5: right step
  assert_step_right_R5: assert property (@(posedge clk) disable iff (rst)
    (press_r && !press_l && seg_n == SEG_BLANK && !field[0])
      |=> (field == ($past(field) >> 1)));

  // R6: simultaneous presses cancel
  assert_both_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (press_l && press_r) |=> $stable(field));

  // R7: left win
  assert_left_win_R7: assert property (@(posedge clk) disable iff (rst)
    (press_l && !press_r && seg_n == SEG_BLANK && field[N_POS-1])
      |=> (seg_n == SEG_ONE && field == '0));

  // R8: right win
  assert_right_win_R8: assert property (@(posedge clk) disable iff (rst)
    (press_r && !press_l && seg_n == SEG_BLANK && field[0])
      |=> (seg_n == SEG_TWO && field == '0));

  // R9: freeze after a win
  assert_freeze_R9: assert property (@(posedge clk) disable iff (rst)
    (seg_n != SEG_BLANK) |=> ($stable(seg_n) && field == '0));
endmodule

bind tow_game tow_game_chk #(.N_POS(N_POS)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .press_l(press_l),
  .press_r(press_r),
  .field  (field),
  .seg_n  (seg_n)
);

// File: tb/tb_tow_game.sv
module tb_tow_game;
  localparam int N = 9;
  localparam logic [6:0] BLANK = 7'b1111111;
  localparam logic [6:0] ONE   = 7'b1111001;
  localparam logic [6:0] TWO   = 7'b0100100;

  typedef struct {
    logic [N-1:0] fld;
    logic [6:0]   seg;
    string        tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bl  = 1'b0;
  logic br  = 1'b0;
  logic [N-1:0] field;
  logic [6:0]   seg_n;

  int total = 0;
  int bad   = 0;
  int pos   = 4;
  int win   = 0;
  exp_t q[$];

  always #10 clk = ~clk;

  tow_game dut (
    .clk(clk), .rst(rst), .btn_left_raw(bl), .btn_right_raw(br),
    .field(field), .seg_n(seg_n)
  );

  function automatic logic [N-1:0] model_field();
    return (win != 0) ? '0 : (N'(1) << pos);
  endfunction

  function automatic logic [6:0] model_seg();
    return (win == 1) ? ONE : (win == 2) ? TWO : BLANK;
  endfunction

  task automatic check(input string tag, input logic [N-1:0] af, input logic [6:0] as,
                       input logic [N-1:0] ef, input logic [6:0] es);
    total++;
    if (af !== ef || as !== es) begin
      bad++;
      $display("FAIL %s field=%b seg=%b expected field=%b seg=%b", tag, af, as, ef, es);
    end
  endtask

  task automatic push(input string tag);
    exp_t e;
    e.fld = model_field();
    e.seg = model_seg();
    e.tag = tag;
    q.push_back(e);
    repeat (2) @(negedge clk);
  endtask

  // model update for one press event (l, r) then drive it
  task automatic press(input bit l, input bit r, input int hold, input string tag);
    if (win == 0 && l && !r) begin
      if (pos == N-1) win = 1; else pos++;
    end else if (win == 0 && r && !l) begin
      if (pos == 0) win = 2; else pos--;
    end
    @(negedge clk);
    bl = l; br = r;
    repeat (hold) @(negedge clk);
    bl = 1'b0; br = 1'b0;
    repeat (4) @(negedge clk);
    push(tag);
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    pos = 4; win = 0;
    push(tag);
  endtask

  // monitor: pop and compare
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(e.tag, field, seg_n, e.fld, e.seg);
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired R1..R10 run hung");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset("R1 reset state");

    // R3: cycle-exact latency of a left press
    @(negedge clk);
    bl = 1'b1;
    @(negedge clk); check("R3 after edge 1", field, seg_n, 9'b000010000, BLANK);
    @(negedge clk); check("R3 after edge 2", field, seg_n, 9'b000010000, BLANK);
    @(negedge clk); check("R3 after edge 3", field, seg_n, 9'b000100000, BLANK);
    bl = 1'b0;
    pos = 5;
    repeat (3) @(negedge clk);

    press(0, 1, 1,  "R5 right step hold 1");
    press(0, 1, 20, "R4 right step hold 20");
    press(1, 0, 5,  "R4 left step hold 5");
    press(1, 1, 3,  "R6 both pressed");
    for (int k = 0; k < 4; k++) press(1, 0, 2, "R5 R2 left walk");
    press(1, 1, 1,  "R6 both at left end");
    press(1, 0, 1,  "R7 left win");
    press(0, 1, 1,  "R9 right after win");
    press(1, 0, 6,  "R9 left after win");
    do_reset("R10 reset after win");
    for (int k = 0; k < 4; k++) press(0, 1, 3, "R5 R2 right walk");
    press(0, 1, 1,  "R8 right win");
    press(1, 0, 2,  "R9 left after right win");
    do_reset("R10 second reset");
    press(1, 0, 1,  "R10 play resumes");

    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule